// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches a bank of external interrupt pins, by default 32, and turns their activity into interrupt requests for the processor. Every pin passes through a two-flop synchroniser and is then handled by its own small state machine. That state machine applies the trigger mode programmed for the pin and keeps the pin's pending flag. A pin can trigger on a low level, a high level, a falling edge, a rising edge or both edges, or it can be switched off. A mask bit decides whether a pending pin reaches the outputs.

The lower pins, by default 0 to 15, each drive a dedicated request output. The upper pins share one request output. Beside that output the block reports the number of the highest-numbered pin that is both pending and unmasked, so a handler can serve the shared group starting from the top.

Software uses a small register port. Writes happen in one cycle and reads are combinational. There are three register kinds, one set per group of eight pins:
- Trigger-mode registers, with a 4-bit field per pin.
- Mask registers.
- Pending registers, where writing a 1 to a bit clears that bit.

Each pin's state machine has five states:
- `LN_OFF`: the pin is disabled.
- `LN_LVL_IDLE`: level mode, with the pin at its inactive level.
- `LN_LVL_ACT`: level mode, with the pin at its active level. The pin is pending.
- `LN_EDGE_IDLE`: edge mode, waiting for an edge.
- `LN_EDGE_HIT`: edge mode, with an edge captured. The pin is pending.

The transitions are:
- From any state, a disabled mode code leads to `LN_OFF`.
- In a level mode, every clock moves the machine to `LN_LVL_ACT` when the synchronised pin is at the active level, and to `LN_LVL_IDLE` otherwise.
- In an edge mode, a selected edge leads to `LN_EDGE_HIT`.
- `LN_EDGE_HIT` stays put until a pending-clear write arrives with no new edge in the same cycle. It then returns to `LN_EDGE_IDLE`.
- Entering an edge mode from `LN_OFF` or from a level state leads to `LN_EDGE_IDLE`, or to `LN_EDGE_HIT` if an edge is seen in that same cycle.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every mask bit is 1 and every pending bit is 0. Every trigger-mode field holds 15 (disabled), so each trigger-mode register reads 0xFFFFFFFF and each mask register reads 0x000000FF. All request outputs are low, and the shared index is 0.
- R2: The register address is {kind[1:0], group[1:0]}. Kind 0 selects the trigger-mode registers, kind 1 the mask registers and kind 2 the pending registers. Group g covers pins 8g to 8g+7, and pin k's bit in a mask or pending register is bit k mod 8. Pin k's trigger-mode field is bits (k mod 8)*4+3 down to (k mod 8)*4 of trigger-mode register k/8. Mode and mask registers read back the value last written.
- R3: In level-low mode (code 0) and level-high mode (code 1), the pending bit follows the synchronised pin. The pending bit is 1 while the pin sits at its active level and 0 otherwise. Clear writes do not affect it. A pin change reaches the outputs after the third rising clock edge that follows the change.
- R4: In falling mode (code 2) or rising mode (code 3), the selected edge sets the pending bit after the same three-edge latency. The bit then stays set after the pin returns to its earlier level. The opposite edge does not set it.
- R5: In both-edges mode (code 4), either a rising or a falling edge sets the pending bit.
- R6: Writing a 1 to a bit of a pending register clears that pin's edge-captured pending bit. The request output falls at the write's clock edge. Bits written as 0 leave their pending bits unchanged, and the pending register reads back the current pending bits.
- R7: Each request is the pending bit AND NOT the mask bit. Setting a mask bit drops the request at the write's clock edge without changing the pending bit seen in the pending register. Clearing the mask bit again raises the request at once.
- R8: Each pin below 16 drives its own bit of `irq_line`, at the index equal to the pin number.
- R9: `irq_shared` is 1 when any pin from 16 to 31 is pending and unmasked. `shared_idx` then gives the highest such pin number. When `irq_shared` is 0, `shared_idx` is 0.
- R10: Mode codes 5 to 15 disable a pin. The pin's pending bit clears one clock edge after the disabling write, and the pin ignores all pin activity.
- R11: Kind 3 addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | NUM_LINES | External interrupt pins, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address {kind, group} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_line | output | NUM_DEDICATED | Dedicated request per lower pin |
| irq_shared | output | 1 | Shared request for the upper pins |
| shared_idx | output | IDX_W | Highest pending, unmasked upper pin number |

## Verification
A pin change counts as cycle zero. It reaches the synchroniser output after the second rising edge and the pin state machine after the third, so every pin-driven check drives its pin just after a falling edge, waits three rising edges and samples on the next falling edge. Mask and pending-clear writes act on the outputs at the edge that takes the write, so those checks sample half a cycle later. A trigger-mode write changes the pending state one edge after that. Each vector in the table first arms the pin, lets the synchroniser settle for four cycles and clears any stale pending bit before it applies the edge or level under test. Directed sequences cover the holding of a captured edge, the effect of mask bits and clear bits, the priority order within the shared group, and the reset values.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int LINES_PER_GRP = 8;
    localparam int FIELD_W       = 4;
    localparam int REG_W         = 32;

    typedef logic [FIELD_W-1:0] trig_mode_t;

    localparam trig_mode_t TRIG_LVL_LOW  = 4'd0;
    localparam trig_mode_t TRIG_LVL_HIGH = 4'd1;
    localparam trig_mode_t TRIG_FALL     = 4'd2;
    localparam trig_mode_t TRIG_RISE     = 4'd3;
    localparam trig_mode_t TRIG_BOTH     = 4'd4;
    localparam trig_mode_t TRIG_OFF      = 4'd15;

    typedef enum logic [2:0] {
        LN_OFF       = 3'd0,
        LN_LVL_IDLE  = 3'd1,
        LN_LVL_ACT   = 3'd2,
        LN_EDGE_IDLE = 3'd3,
        LN_EDGE_HIT  = 3'd4
    } line_state_t;

    typedef enum logic [1:0] {
        RK_CTRL = 2'd0,
        RK_MASK = 2'd1,
        RK_PEND = 2'd2,
        RK_NONE = 2'd3
    } reg_kind_t;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [WIDTH-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign level_o = stage_q[STAGES-1];
    assign prev_o  = prev_q;

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_t mode_i,
    input  logic       level_i,
    input  logic       prev_i,
    input  logic       clr_i,
    output logic       pend_o
);

    line_state_t state_q, state_d;

    logic is_level, is_edge, lvl_hit, edge_hit, rise, fall;

    always_comb begin
        rise     = level_i & ~prev_i;
        fall     = ~level_i & prev_i;
        is_level = (mode_i == TRIG_LVL_LOW) || (mode_i == TRIG_LVL_HIGH);
        is_edge  = (mode_i == TRIG_FALL) || (mode_i == TRIG_RISE) ||
                   (mode_i == TRIG_BOTH);
        lvl_hit  = (mode_i == TRIG_LVL_LOW) ? ~level_i : level_i;
        edge_hit = (rise && ((mode_i == TRIG_RISE) || (mode_i == TRIG_BOTH))) ||
                   (fall && ((mode_i == TRIG_FALL) || (mode_i == TRIG_BOTH)));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF, LN_LVL_IDLE, LN_LVL_ACT, LN_EDGE_IDLE: begin
                if (is_level) begin
                    state_d = lvl_hit ? LN_LVL_ACT : LN_LVL_IDLE;
                end else if (is_edge) begin
                    state_d = edge_hit ? LN_EDGE_HIT : LN_EDGE_IDLE;
                end else begin
                    state_d = LN_OFF;
                end
            end
            LN_EDGE_HIT: begin
                if (is_level) begin
                    state_d = lvl_hit ? LN_LVL_ACT : LN_LVL_IDLE;
                end else if (!is_edge) begin
                    state_d = LN_OFF;
                end else if (clr_i && !edge_hit) begin
                    state_d = LN_EDGE_IDLE;
                end else begin
                    state_d = LN_EDGE_HIT;
                end
            end
            default: state_d = LN_OFF;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LN_LVL_ACT, LN_EDGE_HIT: pend_o = 1'b1;
            default:                 pend_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    localparam int GROUPS = NUM_LINES / LINES_PER_GRP,
    localparam int GRP_W  = $clog2(GROUPS),
    localparam int ADDR_W = GRP_W + 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [REG_W-1:0]                 wdata_i,
    output logic [REG_W-1:0]                 rdata_o,
    input  logic [NUM_LINES-1:0]             pend_i,
    output logic [NUM_LINES-1:0][FIELD_W-1:0] mode_o,
    output logic [NUM_LINES-1:0]             mask_o,
    output logic [NUM_LINES-1:0]             clr_o
);

    logic [GROUPS-1:0][REG_W-1:0]         ctrl_q;
    logic [GROUPS-1:0][LINES_PER_GRP-1:0] mask_q;
    logic [GROUPS-1:0][LINES_PER_GRP-1:0] pend_g;

    reg_kind_t          kind;
    logic [GRP_W-1:0]   grp;
    logic               grp_ok;

    always_comb begin
        kind   = reg_kind_t'(addr_i[ADDR_W-1 -: 2]);
        grp    = addr_i[GRP_W-1:0];
        grp_ok = (int'(grp) < GROUPS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '1;
            mask_q <= '1;
        end else if (we_i && grp_ok) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (int'(grp) == g) begin
                    if (kind == RK_CTRL) ctrl_q[g] <= wdata_i;
                    if (kind == RK_MASK) mask_q[g] <= wdata_i[LINES_PER_GRP-1:0];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_map
        localparam int G = i / LINES_PER_GRP;
        localparam int P = i % LINES_PER_GRP;
        assign mode_o[i] = ctrl_q[G][P*FIELD_W +: FIELD_W];
        assign mask_o[i] = mask_q[G][P];
        assign clr_o[i]  = we_i && (kind == RK_PEND) && (int'(grp) == G) &&
                           wdata_i[P];
        assign pend_g[G][P] = pend_i[i];
    end

    always_comb begin
        rdata_o = '0;
        if (grp_ok) begin
            unique case (kind)
                RK_CTRL: rdata_o = ctrl_q[grp];
                RK_MASK: rdata_o = {{(REG_W-LINES_PER_GRP){1'b0}}, mask_q[grp]};
                RK_PEND: rdata_o = {{(REG_W-LINES_PER_GRP){1'b0}}, pend_g[grp]};
                RK_NONE: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/xirq_prio.sv
module xirq_prio #(
    parameter int N     = 16,
    parameter int BASE  = 16,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(BASE + i);
            end
        end
    end

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES     = 32,
    parameter int NUM_DEDICATED = 16,
    parameter int SYNC_STAGES   = 2,
    localparam int GROUPS  = NUM_LINES / LINES_PER_GRP,
    localparam int GRP_W   = $clog2(GROUPS),
    localparam int ADDR_W  = GRP_W + 2,
    localparam int IDX_W   = $clog2(NUM_LINES),
    localparam int N_SHARE = NUM_LINES - NUM_DEDICATED
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES-1:0]     pins,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic [NUM_DEDICATED-1:0] irq_line,
    output logic                     irq_shared,
    output logic [IDX_W-1:0]         shared_idx
);

    logic [NUM_LINES-1:0]              lvl, prv, pend, mask, clr, active;
    logic [NUM_LINES-1:0][FIELD_W-1:0] mode;

    xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins),
        .level_o (lvl),
        .prev_o  (prv)
    );

    xirq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .pend_i  (pend),
        .mode_o  (mode),
        .mask_o  (mask),
        .clr_o   (clr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        xirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (mode[i]),
            .level_i (lvl[i]),
            .prev_i  (prv[i]),
            .clr_i   (clr[i]),
            .pend_o  (pend[i])
        );
    end

    assign active   = pend & ~mask;
    assign irq_line = active[NUM_DEDICATED-1:0];

    xirq_prio #(.N(N_SHARE), .BASE(NUM_DEDICATED), .IDX_W(IDX_W)) u_prio (
        .req_i (active[NUM_LINES-1:NUM_DEDICATED]),
        .any_o (irq_shared),
        .idx_o (shared_idx)
    );

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int NUM_DEDICATED = 16,
    parameter int ADDR_W        = 4,
    parameter int IDX_W         = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [REG_W-1:0]         reg_wdata,
    input logic [NUM_DEDICATED-1:0] irq_line,
    input logic                     irq_shared,
    input logic [IDX_W-1:0]         shared_idx
);

    localparam logic [ADDR_W-1:0] A_CTRL0 = {RK_CTRL, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] A_MASK0 = {RK_MASK, {(ADDR_W-2){1'b0}}};

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_line == '0) && !irq_shared && (shared_idx == '0));

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_MASK0 && reg_wdata[7:0] == 8'hFF)
        |=> (irq_line[7:0] == 8'h00));

    assert_off_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL0 && reg_wdata == 32'hFFFF_FFFF)
        |=> ##1 (irq_line[7:0] == 8'h00));

    assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_shared |-> (int'(shared_idx) >= NUM_DEDICATED));

    assert_idx_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_shared |-> (shared_idx == '0));

endmodule

bind xirq_ctrl xirq_ctrl_chk #(
    .NUM_DEDICATED (NUM_DEDICATED),
    .ADDR_W        (ADDR_W),
    .IDX_W         (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_line   (irq_line),
    .irq_shared (irq_shared),
    .shared_idx (shared_idx)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    // {line[4:0], mode[3:0], start level, end level, expected request}
    localparam logic [11:0] VEC [NVEC] = '{
        {5'd0,  4'd3, 1'b0, 1'b1, 1'b1},
        {5'd3,  4'd2, 1'b1, 1'b0, 1'b1},
        {5'd5,  4'd3, 1'b1, 1'b0, 1'b0},
        {5'd7,  4'd4, 1'b1, 1'b0, 1'b1},
        {5'd9,  4'd4, 1'b0, 1'b1, 1'b1},
        {5'd12, 4'd0, 1'b1, 1'b0, 1'b1},
        {5'd14, 4'd1, 1'b0, 1'b1, 1'b1},
        {5'd15, 4'd1, 1'b1, 1'b0, 1'b0},
        {5'd17, 4'd3, 1'b0, 1'b1, 1'b1},
        {5'd22, 4'd2, 1'b0, 1'b1, 1'b0},
        {5'd31, 4'd1, 1'b0, 1'b1, 1'b1},
        {5'd26, 4'd6, 1'b0, 1'b1, 1'b0},
        {5'd2,  4'd9, 1'b1, 1'b0, 1'b0},
        {5'd20, 4'd0, 1'b1, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_line;
    logic        irq_shared;
    logic [4:0]  shared_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xirq_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (pins),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_line   (irq_line),
        .irq_shared (irq_shared),
        .shared_idx (shared_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [1:0] grp, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = {kind, grp};
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] kind, input logic [1:0] grp, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {kind, grp};
        #1;
        d = reg_rdata;
    endtask

    task automatic settle3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int          ln, pos;
        logic [1:0]  g;
        logic [3:0]  md;
        logic        st, en, ex;
        logic [31:0] d, cv;
        string       tag;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            rd(2'd0, 2'(k), d); chk("R1 ctrl reset", d, 32'hFFFF_FFFF);
            rd(2'd1, 2'(k), d); chk("R1 mask reset", d, 32'h0000_00FF);
            rd(2'd2, 2'(k), d); chk("R1 pend reset", d, 32'h0);
        end
        chk("R1 outputs reset", {15'd0, irq_line, irq_shared}, 32'h0);
        chk("R1 idx reset", {27'd0, shared_idx}, 32'h0);

        // R11 unused kind; R2 readback
        wr(2'd3, 2'd0, 32'h1234_5678);
        rd(2'd3, 2'd0, d); chk("R11 kind3 read", d, 32'h0);
        rd(2'd0, 2'd0, d); chk("R11 kind3 write ignored", d, 32'hFFFF_FFFF);
        wr(2'd0, 2'd1, 32'hFFFF_F4FF);
        rd(2'd0, 2'd1, d); chk("R2 ctrl readback", d, 32'hFFFF_F4FF);
        wr(2'd0, 2'd1, 32'hFFFF_FFFF);

        // table of vectors: R3 R4 R5 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            ln  = int'(VEC[v][11:7]);
            md  = VEC[v][6:3];
            st  = VEC[v][2];
            en  = VEC[v][1];
            ex  = VEC[v][0];
            g   = 2'(ln / 8);
            pos = ln % 8;
            cv  = (32'hFFFF_FFFF & ~(32'hF << (pos*4))) | (32'(md) << (pos*4));
            if (md <= 4'd1)      tag = "R3 level";
            else if (md <= 4'd3) tag = "R4 edge";
            else if (md == 4'd4) tag = "R5 both";
            else                 tag = "R10 disabled";
            tag = $sformatf("%s line %0d %s", tag, ln, (ln < 16) ? "R8" : "R9");
            wr(2'd0, g, cv);
            pins[ln] = st;
            repeat (4) @(negedge clk);
            wr(2'd2, g, 32'(1) << pos);
            wr(2'd1, g, 32'hFF & ~(32'(1) << pos));
            @(negedge clk) pins[ln] = en;
            settle3();
            if (ln < 16) chk(tag, {31'd0, irq_line[ln]}, {31'd0, ex});
            else chk(tag, {26'd0, irq_shared, shared_idx},
                     {26'd0, ex, ex ? 5'(ln) : 5'd0});
            wr(2'd1, g, 32'hFF);
            wr(2'd0, g, 32'hFFFF_FFFF);
            wr(2'd2, g, 32'hFF);
        end

        // R4 hold, R6 clear, R7 mask on line 1
        wr(2'd0, 2'd0, 32'hFFFF_FF3F);
        pins[1] = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd2, 2'd0, 32'hFF);
        wr(2'd1, 2'd0, 32'hFD);
        @(negedge clk) pins[1] = 1'b1;
        settle3();
        chk("R4 rise sets", {31'd0, irq_line[1]}, 32'd1);
        @(negedge clk) pins[1] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R4 held after pin low", {31'd0, irq_line[1]}, 32'd1);
        wr(2'd2, 2'd0, 32'hFD);
        chk("R6 zero bit no effect", {31'd0, irq_line[1]}, 32'd1);
        rd(2'd2, 2'd0, d); chk("R6 pend readback", d, 32'h02);
        wr(2'd1, 2'd0, 32'hFF);
        chk("R7 mask drops request", {31'd0, irq_line[1]}, 32'd0);
        rd(2'd2, 2'd0, d); chk("R7 pending kept under mask", d, 32'h02);
        wr(2'd1, 2'd0, 32'hFD);
        chk("R7 unmask raises request", {31'd0, irq_line[1]}, 32'd1);
        wr(2'd2, 2'd0, 32'h02);
        chk("R6 clear drops request", {31'd0, irq_line[1]}, 32'd0);
        rd(2'd2, 2'd0, d); chk("R6 pend cleared", d, 32'h0);

        // R10 disabling clears a level-pending line
        wr(2'd0, 2'd0, 32'hFFFF_FF1F);
        @(negedge clk) pins[1] = 1'b1;
        settle3();
        chk("R3 level high active", {31'd0, irq_line[1]}, 32'd1);
        wr(2'd0, 2'd0, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R10 disable clears pending", {31'd0, irq_line[1]}, 32'd0);
        wr(2'd1, 2'd0, 32'hFF);
        pins[1] = 1'b0;

        // R9 priority among shared lines 18 and 25
        wr(2'd0, 2'd2, 32'hFFFF_F3FF);
        wr(2'd0, 2'd3, 32'hFFFF_FF3F);
        pins[18] = 1'b0; pins[25] = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd2, 2'd2, 32'hFF);
        wr(2'd2, 2'd3, 32'hFF);
        wr(2'd1, 2'd2, 32'hFB);
        wr(2'd1, 2'd3, 32'hFD);
        @(negedge clk) begin pins[18] = 1'b1; pins[25] = 1'b1; end
        settle3();
        chk("R9 highest first", {26'd0, irq_shared, shared_idx}, {26'd0, 1'b1, 5'd25});
        wr(2'd2, 2'd3, 32'h02);
        chk("R9 next lower", {26'd0, irq_shared, shared_idx}, {26'd0, 1'b1, 5'd18});
        wr(2'd2, 2'd2, 32'h04);
        chk("R9 none left", {26'd0, irq_shared, shared_idx}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule